// File: doc/BRIEF.md
# Boot-Remap Address Decoder

This block is the first-level address decoder that sits in front of one bus master. It splits a 32-bit address space into sixteen 256 MB areas, using the top four address bits. Each access goes to one slave port: a local memory inside the lowest area, one of eight external chip selects, or the peripheral bridge. An access to an area or region that nothing decodes raises an abort. The decoder takes only the address bits above the 1 MB boundary, because nothing below that boundary affects the routing.

What answers at address zero can change. While reset is low, the block captures a boot-select pin. Until software remaps, the lowest 1 MB region points at the on-chip ROM when that pin was high, and at external chip select 0 when it was low. A remap register is set and cleared by single-cycle strobes. While it is set, the lowest region points at the shared SRAM. Every master carries its own instance of the decoder, so each master has its own remap state. The decode itself is combinational, so outputs follow the address in the same cycle.

Top module: `bootmap_decoder`

## Requirements
- R1: With `acc_valid` high, an address whose bits 31:28 equal n, for n from 1 to 8, gives `slave_sel`=7 (external bus), `ebi_cs`=n-1, `abort`=0 and `int_hit`=0.
- R2: With `acc_valid` high, bits 31:28 equal to 15 give `slave_sel`=8 (peripheral bridge), `ebi_cs`=0, `abort`=0 and `int_hit`=0.
- R3: With `acc_valid` high, bits 31:28 in the range 9 to 14 give `abort`=1, `slave_sel`=0, `ebi_cs`=0 and `int_hit`=0.
- R4: Inside area 0, the 1 MB region index is address bits 27:20. Regions 1 to 6 give `slave_sel` codes 1 to 6 in that order: instruction TCM SRAM, data TCM SRAM, shared SRAM, ROM, USB host registers, LCD controller. Bit k-1 of `int_hit` is the only bit set for code k.
- R5: Inside area 0, regions 7 to 255 give `abort`=1, `slave_sel`=0 and `int_hit`=0.
- R6: Region 0 of area 0 gives the ROM (code 4, `int_hit`=001000b) while remap is clear and the captured boot pin is 1.
- R7: Region 0 of area 0 gives the external bus with chip select 0 (code 7, `ebi_cs`=0, `int_hit`=0) while remap is clear and the captured boot pin is 0.
- R8: While remap is set, region 0 of area 0 gives the shared SRAM (code 3, `int_hit`=000100b), whatever the boot pin was. Regions 1 to 6 keep their R4 mapping.
- R9: Remap is clear after reset. A `remap_set` pulse sets it from the next cycle, and a `remap_clr` pulse clears it. If both arrive in the same cycle, the set wins.
- R10: `boot_pin` is captured on each clock edge while `rst_n` is low. Changes to it after reset is released have no effect on decoding.
- R11: With `acc_valid` low, the outputs are `slave_sel`=0, `ebi_cs`=0, `abort`=0 and `int_hit`=0, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the boot pin is captured while it is low |
| boot_pin | input | 1 | Boot-select level: 1 selects ROM, 0 selects external chip select 0 |
| remap_set | input | 1 | One-cycle strobe that sets the remap state |
| remap_clr | input | 1 | One-cycle strobe that clears the remap state |
| acc_valid | input | 1 | Access in progress; the outputs are idle when low |
| addr_hi | input | 12 | Address bits 31:20 of the access |
| slave_sel | output | 4 | Target slave code (0 none, 1-6 internal, 7 external bus, 8 peripheral bridge) |
| ebi_cs | output | 3 | External chip select index, valid with code 7 |
| abort | output | 1 | The access falls in an undecoded area or region |
| int_hit | output | 6 | One-hot select of the internal target, bit k-1 for code k |

## Verification
The hardest behaviour to reach from the ports is the boot capture, because the pin is only sampled during reset. The stimulus resets the block several times with different pin levels. After each release it drives the pin to the other level and checks that the decode of address zero does not move. It then runs the same-cycle set-and-clear collision and checks, through the address-zero decode, that the remap state ends up set.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic [3:0] {
      SL_NONE    = 4'd0,
      SL_TCM_I   = 4'd1,
      SL_TCM_D   = 4'd2,
      SL_SRAM_SH = 4'd3,
      SL_ROM     = 4'd4,
      SL_USBH    = 4'd5,
      SL_LCD     = 4'd6,
      SL_EXT     = 4'd7,
      SL_PERIPH  = 4'd8
   } slave_e;

   localparam int SEL_W   = 4;
   localparam int NUM_INT = 6;
endpackage

// File: rtl/bm_boot_latch.sv
module bm_boot_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_pin,
   output logic boot_q
);
   // Follows the pin on every edge while reset is held, frozen afterwards.
   always_ff @(posedge clk) begin
      if (!rst_n) boot_q <= boot_pin;
   end
endmodule

// File: rtl/bm_remap_reg.sv
module bm_remap_reg #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic remap_q
);
   logic remap_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set_i)      remap_d = 1'b1;
            else if (clr_i) remap_d = 1'b0;
            else            remap_d = remap_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr_i)      remap_d = 1'b0;
            else if (set_i) remap_d = 1'b1;
            else            remap_d = remap_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) remap_q <= 1'b0;
      else        remap_q <= remap_d;
   end
endmodule

// File: rtl/bm_area_dec.sv
module bm_area_dec #(
   parameter int AREA_W      = 4,
   parameter int NUM_CS      = 8,
   parameter int EBI_FIRST   = 1,
   parameter int PERIPH_AREA = 15,
   parameter int CS_W        = 3
) (
   input  logic [AREA_W-1:0] area_i,
   output logic              is_int,
   output logic              is_ext,
   output logic              is_periph,
   output logic [CS_W-1:0]   cs_o,
   output logic              unmapped
);
   localparam int NUM_AREAS = 1 << AREA_W;

   logic [NUM_AREAS-1:0] ext_map;

   generate
      for (genvar g = 0; g < NUM_AREAS; g++) begin : g_ext_map
         if (g >= EBI_FIRST && g < EBI_FIRST + NUM_CS) begin : g_on
            assign ext_map[g] = 1'b1;
         end else begin : g_off
            assign ext_map[g] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      cs_o = '0;
      for (int k = 0; k < NUM_CS; k++) begin
         if (area_i == AREA_W'(EBI_FIRST + k)) cs_o = CS_W'(k);
      end
   end

   assign is_int    = (area_i == '0);
   assign is_ext    = ext_map[area_i];
   assign is_periph = (area_i == AREA_W'(PERIPH_AREA));
   assign unmapped  = !(is_int || is_ext || is_periph);
endmodule

// File: rtl/bm_int_dec.sv
module bm_int_dec #(
   parameter int RGN_W = 8
) (
   input  logic [RGN_W-1:0] rgn_i,
   input  logic             boot_q,
   input  logic             remap_q,
   output bm_pkg::slave_e   slave_o,
   output logic             unmapped_o
);
   import bm_pkg::*;

   always_comb begin
      unmapped_o = 1'b0;
      slave_o    = SL_NONE;
      if (rgn_i == RGN_W'(0)) begin
         if (remap_q)     slave_o = SL_SRAM_SH;
         else if (boot_q) slave_o = SL_ROM;
         else             slave_o = SL_EXT;
      end
      else if (rgn_i == RGN_W'(1)) slave_o = SL_TCM_I;
      else if (rgn_i == RGN_W'(2)) slave_o = SL_TCM_D;
      else if (rgn_i == RGN_W'(3)) slave_o = SL_SRAM_SH;
      else if (rgn_i == RGN_W'(4)) slave_o = SL_ROM;
      else if (rgn_i == RGN_W'(5)) slave_o = SL_USBH;
      else if (rgn_i == RGN_W'(6)) slave_o = SL_LCD;
      else unmapped_o = 1'b1;
   end
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder #(
   parameter int ADDR_W      = 32,
   parameter int AREA_W      = 4,
   parameter int RGN_LSB     = 20,
   parameter int NUM_CS      = 8,
   parameter int EBI_FIRST   = 1,
   parameter int PERIPH_AREA = 15,
   parameter bit SET_WINS    = 1'b1,
   localparam int HI_W       = ADDR_W - RGN_LSB,
   localparam int RGN_W      = HI_W - AREA_W,
   localparam int CS_W       = $clog2(NUM_CS),
   localparam int NINT       = bm_pkg::NUM_INT,
   localparam int SW         = bm_pkg::SEL_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            boot_pin,
   input  logic            remap_set,
   input  logic            remap_clr,
   input  logic            acc_valid,
   input  logic [HI_W-1:0] addr_hi,
   output logic [SW-1:0]   slave_sel,
   output logic [CS_W-1:0] ebi_cs,
   output logic            abort,
   output logic [NINT-1:0] int_hit
);
   import bm_pkg::*;

   generate
      if (RGN_W < 3) begin : g_bad_rgn
         $error("region field too narrow for the internal map");
      end
      if (NUM_CS < 2) begin : g_bad_cs
         $error("at least two chip selects are required");
      end
      if (EBI_FIRST < 1 || EBI_FIRST + NUM_CS > PERIPH_AREA) begin : g_bad_ebi
         $error("external areas overlap area 0 or the peripheral area");
      end
      if (PERIPH_AREA >= (1 << AREA_W)) begin : g_bad_per
         $error("peripheral area outside the area field");
      end
   endgenerate

   logic            boot_q;
   logic            remap_q;
   logic            a_int, a_ext, a_per, a_unm;
   logic [CS_W-1:0] a_cs;
   slave_e          i_slave;
   logic            i_unm;
   slave_e          sel;

   bm_boot_latch u_boot (
      .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .boot_q(boot_q)
   );

   bm_remap_reg #(.SET_WINS(SET_WINS)) u_remap (
      .clk(clk), .rst_n(rst_n), .set_i(remap_set), .clr_i(remap_clr),
      .remap_q(remap_q)
   );

   bm_area_dec #(
      .AREA_W(AREA_W), .NUM_CS(NUM_CS), .EBI_FIRST(EBI_FIRST),
      .PERIPH_AREA(PERIPH_AREA), .CS_W(CS_W)
   ) u_area (
      .area_i(addr_hi[HI_W-1 -: AREA_W]),
      .is_int(a_int), .is_ext(a_ext), .is_periph(a_per),
      .cs_o(a_cs), .unmapped(a_unm)
   );

   bm_int_dec #(.RGN_W(RGN_W)) u_int (
      .rgn_i(addr_hi[RGN_W-1:0]), .boot_q(boot_q), .remap_q(remap_q),
      .slave_o(i_slave), .unmapped_o(i_unm)
   );

   always_comb begin
      sel    = SL_NONE;
      ebi_cs = '0;
      abort  = 1'b0;
      if (acc_valid) begin
         if (a_int) begin
            if (i_unm) abort = 1'b1;
            else       sel   = i_slave;
         end else if (a_ext) begin
            sel    = SL_EXT;
            ebi_cs = a_cs;
         end else if (a_per) begin
            sel = SL_PERIPH;
         end else if (a_unm) begin
            abort = 1'b1;
         end
      end
   end

   assign slave_sel = sel;

   generate
      for (genvar i = 0; i < NINT; i++) begin : g_hit
         assign int_hit[i] = (sel == slave_e'(i + 1));
      end
   endgenerate
endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
   parameter int HI_W        = 12,
   parameter int AREA_W      = 4,
   parameter int CS_W        = 3,
   parameter int NINT        = 6,
   parameter int NUM_CS      = 8,
   parameter int EBI_FIRST   = 1,
   parameter int PERIPH_AREA = 15
) (
   input logic            clk,
   input logic            rst_n,
   input logic            remap_set,
   input logic            remap_clr,
   input logic            acc_valid,
   input logic [HI_W-1:0] addr_hi,
   input logic [3:0]      slave_sel,
   input logic [CS_W-1:0] ebi_cs,
   input logic            abort,
   input logic [NINT-1:0] int_hit,
   input logic            boot_q,
   input logic            remap_q
);
   logic [AREA_W-1:0] area;
   logic              zero_rgn;
   assign area     = addr_hi[HI_W-1 -: AREA_W];
   assign zero_rgn = (addr_hi == '0);

   a_r1_ext_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && int'(area) >= EBI_FIRST && int'(area) < EBI_FIRST + NUM_CS)
      |-> (slave_sel == 4'd7 && ebi_cs == CS_W'(int'(area) - EBI_FIRST)));

   a_r2_periph: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && int'(area) == PERIPH_AREA) |-> (slave_sel == 4'd8 && !abort));

   a_r3_hole_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && int'(area) >= EBI_FIRST + NUM_CS && int'(area) < PERIPH_AREA)
      |-> (abort && slave_sel == 4'd0));

   a_r4_itcm: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && addr_hi == HI_W'(1)) |-> (slave_sel == 4'd1 && int_hit[0]));

   a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(int_hit));

   a_r6_boot_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && zero_rgn && !remap_q && boot_q) |-> (slave_sel == 4'd4));

   a_r7_boot_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && zero_rgn && !remap_q && !boot_q)
      |-> (slave_sel == 4'd7 && ebi_cs == '0));

   a_r8_remapped: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && zero_rgn && remap_q) |-> (slave_sel == 4'd3));

   a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
      remap_set |=> remap_q);

   a_r9_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_clr && !remap_set) |=> !remap_q);

   a_r10_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(boot_q));

   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (slave_sel == 4'd0 && !abort && int_hit == '0 && ebi_cs == '0));
endmodule

bind bootmap_decoder bm_checker #(
   .HI_W(HI_W), .AREA_W(AREA_W), .CS_W(CS_W), .NINT(NINT),
   .NUM_CS(NUM_CS), .EBI_FIRST(EBI_FIRST), .PERIPH_AREA(PERIPH_AREA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .remap_set(remap_set), .remap_clr(remap_clr),
   .acc_valid(acc_valid), .addr_hi(addr_hi), .slave_sel(slave_sel),
   .ebi_cs(ebi_cs), .abort(abort), .int_hit(int_hit),
   .boot_q(boot_q), .remap_q(remap_q)
);

// File: tb/sim_bootmap_decoder.sv
module sim_bootmap_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_pin = 1'b1;
   logic        remap_set = 1'b0;
   logic        remap_clr = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] addr = 32'h0;
   logic [3:0]  slave_sel;
   logic [2:0]  ebi_cs;
   logic        abort;
   logic [5:0]  int_hit;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bootmap_decoder u0 (
      .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin),
      .remap_set(remap_set), .remap_clr(remap_clr),
      .acc_valid(acc_valid), .addr_hi(addr[31:20]),
      .slave_sel(slave_sel), .ebi_cs(ebi_cs), .abort(abort), .int_hit(int_hit)
   );

   // {address, slave code, chip select, abort, internal one-hot}, remap clear, boot pin 1
   localparam int NVEC = 16;
   localparam logic [45:0] VEC [NVEC] = '{
      {32'h0000_0000, 4'd4, 3'd0, 1'b0, 6'b001000},
      {32'h0010_0004, 4'd1, 3'd0, 1'b0, 6'b000001},
      {32'h0020_0000, 4'd2, 3'd0, 1'b0, 6'b000010},
      {32'h003F_FFFC, 4'd3, 3'd0, 1'b0, 6'b000100},
      {32'h0040_0000, 4'd4, 3'd0, 1'b0, 6'b001000},
      {32'h0050_0010, 4'd5, 3'd0, 1'b0, 6'b010000},
      {32'h0060_0000, 4'd6, 3'd0, 1'b0, 6'b100000},
      {32'h0070_0000, 4'd0, 3'd0, 1'b1, 6'b000000},
      {32'h0FF0_0000, 4'd0, 3'd0, 1'b1, 6'b000000},
      {32'h1000_0000, 4'd7, 3'd0, 1'b0, 6'b000000},
      {32'h2345_6789, 4'd7, 3'd1, 1'b0, 6'b000000},
      {32'h8FFF_FFFF, 4'd7, 3'd7, 1'b0, 6'b000000},
      {32'h9000_0000, 4'd0, 3'd0, 1'b1, 6'b000000},
      {32'hE000_0000, 4'd0, 3'd0, 1'b1, 6'b000000},
      {32'hF000_0000, 4'd8, 3'd0, 1'b0, 6'b000000},
      {32'hFFFF_FFFF, 4'd8, 3'd0, 1'b0, 6'b000000}
   };

   task automatic check(input string tag, input logic [3:0] es, input logic [2:0] ec,
                        input logic ea, input logic [5:0] ei);
      total++;
      if ({slave_sel, ebi_cs, abort, int_hit} !== {es, ec, ea, ei}) begin
         fails++;
         $display("FAIL %s addr=%h: got slave=%0d cs=%0d abort=%b int=%b, expected slave=%0d cs=%0d abort=%b int=%b",
                  tag, addr, slave_sel, ebi_cs, abort, int_hit, es, ec, ea, ei);
      end
   endtask

   task automatic apply(input logic v, input logic [31:0] a);
      @(negedge clk);
      acc_valid = v;
      addr      = a;
      #2;
   endtask

   task automatic pulse(input logic s, input logic c);
      @(negedge clk);
      remap_set = s;
      remap_clr = c;
      @(negedge clk);
      remap_set = 1'b0;
      remap_clr = 1'b0;
   endtask

   task automatic do_reset(input logic b);
      @(negedge clk);
      acc_valid = 1'b0;
      rst_n     = 1'b0;
      boot_pin  = b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         summary();
      end
   end

   initial begin
      do_reset(1'b1);

      // reset state: remap clear, boot pin 1 -> ROM at zero (R9, R6)
      apply(1'b1, 32'h0000_0000);
      check("R9", 4'd4, 3'd0, 1'b0, 6'b001000);

      for (int i = 0; i < NVEC; i++) begin
         logic [45:0] v;
         logic [31:0] a;
         string       tag;
         v = VEC[i];
         a = v[45:14];
         tag = (a[31:28] == 4'd0) ? ((a[27:20] == 8'd0) ? "R6" : (a[27:20] < 8'd7 ? "R4" : "R5"))
             : (a[31:28] <= 4'd8) ? "R1" : (a[31:28] == 4'd15) ? "R2" : "R3";
         apply(1'b1, a);
         check(tag, v[13:10], v[9:7], v[6], v[5:0]);
      end

      // R11: idle outputs when no access, even on an aborting address
      apply(1'b0, 32'h9000_0000);
      check("R11", 4'd0, 3'd0, 1'b0, 6'b000000);
      apply(1'b0, 32'h3000_0000);
      check("R11", 4'd0, 3'd0, 1'b0, 6'b000000);

      // R10: boot pin moves after release, decode of zero stays ROM
      boot_pin = 1'b0;
      repeat (3) @(negedge clk);
      apply(1'b1, 32'h0000_0000);
      check("R10", 4'd4, 3'd0, 1'b0, 6'b001000);

      // R9 set -> R8 shared SRAM at zero
      pulse(1'b1, 1'b0);
      apply(1'b1, 32'h0000_0000);
      check("R8", 4'd3, 3'd0, 1'b0, 6'b000100);
      apply(1'b1, 32'h0040_0000);
      check("R8", 4'd4, 3'd0, 1'b0, 6'b001000);

      // R9 clear -> back to ROM
      pulse(1'b0, 1'b1);
      apply(1'b1, 32'h0000_0000);
      check("R9", 4'd4, 3'd0, 1'b0, 6'b001000);

      // R9 both strobes together: set wins
      pulse(1'b1, 1'b1);
      apply(1'b1, 32'h0000_0000);
      check("R9", 4'd3, 3'd0, 1'b0, 6'b000100);

      // new reset with boot pin 0: remap cleared, zero -> external cs0 (R7)
      do_reset(1'b0);
      apply(1'b1, 32'h0000_0000);
      check("R7", 4'd7, 3'd0, 1'b0, 6'b000000);
      apply(1'b1, 32'h1230_0000);
      check("R1", 4'd7, 3'd0, 1'b0, 6'b000000);

      // R10: pin raised after release has no effect
      boot_pin = 1'b1;
      repeat (3) @(negedge clk);
      apply(1'b1, 32'h0000_0000);
      check("R10", 4'd7, 3'd0, 1'b0, 6'b000000);

      // R8: remap overrides the external boot choice
      pulse(1'b1, 1'b0);
      apply(1'b1, 32'h0000_0000);
      check("R8", 4'd3, 3'd0, 1'b0, 6'b000100);

      // R9: reset clears remap, boot pin 1 taken again
      do_reset(1'b1);
      apply(1'b1, 32'h0000_0000);
      check("R9", 4'd4, 3'd0, 1'b0, 6'b001000);

      done = 1'b1;
      summary();
   end
endmodule